// File: doc/BRIEF.md
# Integer ALU with Carry, Overflow and Range Request

This block is the 32-bit integer execution unit of a processor pipeline. It takes two operands, a four-bit operation code and the current carry, overflow and overflow-exception-enable state. It returns a result, a destination write enable, the new carry and overflow flags and a one-cycle range-exception request. Register-file writeback and exception vectoring belong to the surrounding pipeline. The pipeline uses the write enable and the request pulse to drive them.

Addition, subtraction, logical operations, shifts and rotation finish at the edge that accepts the request. Multiply and divide run iteratively, one bit per cycle. While they run, `busy_o` is high and new requests are ignored. Every operation, single-cycle or iterative, reports completion with a one-cycle `done_o` pulse. Result and flags are valid in that cycle and are held until the next completion.

Top module: `int_alu`

## Requirements
- R1: Operation codes on `op_i`: 0 add, 1 add-with-carry, 2 subtract, 3 signed multiply, 4 unsigned multiply, 5 signed divide, 6 unsigned divide, 7 and, 8 or, 9 xor, 10 shift left, 11 logical shift right, 12 arithmetic shift right, 13 rotate right. A request is accepted at a rising edge with `start_i` high and `busy_o` low. For codes 0-2 and 7-15, `done_o` is high in the cycle right after the accepting edge. Outputs hold their values until the next completion.
- R2: Add returns a+b (mod 2^32) and ignores `cy_i`. Overflow is set when both operands share a sign and the sum's sign differs from it. Carry is set when the unsigned sum is below unsigned a.
- R3: Add-with-carry returns a+b+`cy_i`. With carry-in 1, carry is set when the unsigned result is at most unsigned a, so 0 + 0xFFFFFFFF + 1 gives result 0 with carry 1. Overflow follows the R2 sign rule.
- R4: Subtract returns a-b. Overflow is set when a and b differ in sign and the result's sign differs from a's. Carry is set when unsigned b exceeds unsigned a.
- R5: Signed multiply returns the low 32 bits of the product. Overflow is set when the full signed product falls outside the signed 32-bit range. Carry is set when the unsigned product of the same bit patterns exceeds 0xFFFFFFFF.
- R6: Unsigned multiply returns the low 32 bits and clears overflow, whatever `ov_i` is. Carry is set when the 64-bit product needs more than 32 bits.
- R7: For a non-zero divisor, divide writes the quotient (signed divide truncates toward zero) with `wr_en_o` high, and clears carry and overflow.
- R8: A divide by zero completes in the cycle right after the accepting edge. It gives `wr_en_o` low, carry 1, overflow 0 and result 0.
- R9: The range request `range_exc_o` is `ove_i` AND the new overflow for add, add-with-carry, subtract and signed multiply. It is `ove_i` AND the new carry for both divides. It is 0 for unsigned multiply.
- R10: Logical, shift and rotate operations, and the unassigned codes 14 and 15, return `cy_i` and `ov_i` unchanged as the new flags and never raise a range request. Codes 14 and 15 return 0.
- R11: Shifts and rotate use only the low 5 bits of b. A rotate by a multiple of 32 returns a unchanged.
- R12: Multiply and divide with a non-zero divisor raise `done_o` in the cycle after the 33rd rising edge following the accepting edge, for exactly one cycle. `busy_o` is high in between. A `start_i` while busy has no effect on the completing result or on the number of completions.
- R13: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code (R1) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand / shift amount / divisor |
| cy_i | input | 1 | Current carry flag |
| ov_i | input | 1 | Current overflow flag |
| ove_i | input | 1 | Overflow exception enable |
| busy_o | output | 1 | Iterative operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination should be written |
| cy_o | output | 1 | New carry flag |
| ov_o | output | 1 | New overflow flag |
| range_exc_o | output | 1 | Range exception request |

## Verification
Several rules are checked by the assertions in every completion cycle, whatever the operands:
- the range request matches the enable combined with the right flag;
- divides and unsigned multiplies never report overflow;
- a divide suppresses the write exactly when it reports carry;
- logical operations pass the incoming flags through;
- completion is a single-cycle pulse outside `busy_o`.

Only the bench scenarios can show the arithmetic values themselves. These include the less-or-equal carry corner of add-with-carry, the signed-product range test, truncation toward zero, the five-bit masking of shift and rotate amounts, the 33-cycle latency and the rejection of a request made while busy.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_MUL  = 4'd3,
    OP_MULU = 4'd4,  OP_DIV  = 4'd5,  OP_DIVU = 4'd6,  OP_AND  = 4'd7,
    OP_OR   = 4'd8,  OP_XOR  = 4'd9,  OP_SLL  = 4'd10, OP_SRL  = 4'd11,
    OP_SRA  = 4'd12, OP_ROR  = 4'd13, OP_RSV0 = 4'd14, OP_RSV1 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_DIV  = 2'd2
  } alu_st_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cy_o,
  output logic             ov_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   sum;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, (sub_i | cin_i)};
    res_o = sum[MSB:0];
    // carry-out equals "result <= a" when carry-in is set, "result < a" otherwise
    cy_o  = sub_i ? ~sum[WIDTH] : sum[WIDTH];
    ov_o  = (a_i[MSB] == b_eff[MSB]) && (sum[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int SW = $clog2(WIDTH);

  logic [SW-1:0]      amt;
  logic [2*WIDTH-1:0] rot_w;

  always_comb begin
    amt   = b_i[SW-1:0];
    rot_w = {a_i, a_i} >> amt;
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_SLL:  res_o = a_i << amt;
      OP_SRL:  res_o = a_i >> amt;
      OP_SRA:  res_o = $unsigned($signed(a_i) >>> amt);
      OP_ROR:  res_o = rot_w[WIDTH-1:0];
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             done_o,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] mcand_q, hi_q, lo_q;
  logic [WIDTH:0]   psum;

  assign psum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        cnt_q   <= CW'(WIDTH);
        mcand_q <= a_i;
        hi_q    <= '0;
        lo_q    <= b_i;
      end else if (cnt_q != '0) begin
        hi_q   <= psum[WIDTH:1];
        lo_q   <= {psum[0], lo_q[WIDTH-1:1]};
        cnt_q  <= cnt_q - 1'b1;
        done_o <= (cnt_q == CW'(1));
      end
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  assert_mul_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_mul_idle_when_done_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cnt_q == '0);
endmodule

// File: rtl/alu_div.sv
module alu_div #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [WIDTH-1:0] num_i,
  input  logic [WIDTH-1:0] den_i,
  output logic             done_o,
  output logic [WIDTH-1:0] quo_o
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] den_q, rem_q, quo_q;
  logic [WIDTH:0]   rem_sh;
  logic [WIDTH+1:0] diff;

  always_comb begin
    rem_sh = {rem_q, quo_q[WIDTH-1]};
    diff   = {1'b0, rem_sh} - {2'b00, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        cnt_q <= CW'(WIDTH);
        den_q <= den_i;
        rem_q <= '0;
        quo_q <= num_i;
      end else if (cnt_q != '0) begin
        if (diff[WIDTH+1]) begin
          rem_q <= rem_sh[WIDTH-1:0];
          quo_q <= {quo_q[WIDTH-2:0], 1'b0};
        end else begin
          rem_q <= diff[WIDTH-1:0];
          quo_q <= {quo_q[WIDTH-2:0], 1'b1};
        end
        cnt_q  <= cnt_q - 1'b1;
        done_o <= (cnt_q == CW'(1));
      end
    end
  end

  assign quo_o = quo_q;

  assert_div_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_div_rem_below_den_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rem_q < den_q);
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cy_i,
  input  logic             ov_i,
  input  logic             ove_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic             cy_o,
  output logic             ov_o,
  output logic             range_exc_o
);
  localparam int MSB = WIDTH - 1;

  alu_st_e          st_q;
  alu_op_e          op_in, op_q;
  logic             cyin_q, ovin_q, ove_q, neg_q;
  logic [WIDTH-1:0] a_q, b_q;
  logic             done_q, wr_q, cy_q, ov_q, rng_q;
  logic [WIDTH-1:0] res_q;

  logic             accept, is_mul, is_div, div_signed, div_zero;
  logic [WIDTH-1:0] as_res, lg_res, num_abs, den_abs;
  logic             as_cy, as_ov;
  logic             mul_done, div_done;
  logic [WIDTH-1:0] mul_hi, mul_lo, div_quo;
  logic [WIDTH-1:0] hi_signed;
  logic             mul_sov;

  assign op_in      = alu_op_e'(op_i);
  assign accept     = start_i && (st_q == ST_IDLE);
  assign is_mul     = (op_in == OP_MUL)  || (op_in == OP_MULU);
  assign is_div     = (op_in == OP_DIV)  || (op_in == OP_DIVU);
  assign div_signed = (op_in == OP_DIV);
  assign div_zero   = (b_i == '0);
  assign num_abs    = (div_signed && a_i[MSB]) ? -a_i : a_i;
  assign den_abs    = (div_signed && b_i[MSB]) ? -b_i : b_i;

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (op_in == OP_SUB),
    .cin_i ((op_in == OP_ADDC) && cy_i),
    .res_o (as_res),
    .cy_o  (as_cy),
    .ov_o  (as_ov)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op_i  (op_in),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (lg_res)
  );

  alu_mul #(.WIDTH(WIDTH)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (accept && is_mul),
    .a_i    (a_i),
    .b_i    (b_i),
    .done_o (mul_done),
    .hi_o   (mul_hi),
    .lo_o   (mul_lo)
  );

  alu_div #(.WIDTH(WIDTH)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (accept && is_div && !div_zero),
    .num_i  (num_abs),
    .den_i  (den_abs),
    .done_o (div_done),
    .quo_o  (div_quo)
  );

  // signed upper half from the unsigned product by two-term correction
  always_comb begin
    hi_signed = mul_hi - (a_q[MSB] ? b_q : '0) - (b_q[MSB] ? a_q : '0);
    mul_sov   = (hi_signed != {WIDTH{mul_lo[MSB]}});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_ADD;
      cyin_q <= 1'b0;
      ovin_q <= 1'b0;
      ove_q  <= 1'b0;
      neg_q  <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      cy_q   <= 1'b0;
      ov_q   <= 1'b0;
      rng_q  <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          op_q   <= op_in;
          cyin_q <= cy_i;
          ovin_q <= ov_i;
          ove_q  <= ove_i;
          a_q    <= a_i;
          b_q    <= b_i;
          neg_q  <= div_signed && (a_i[MSB] ^ b_i[MSB]);
          unique case (op_in)
            OP_ADD, OP_ADDC, OP_SUB: begin
              res_q  <= as_res;
              cy_q   <= as_cy;
              ov_q   <= as_ov;
              rng_q  <= ove_i && as_ov;
              wr_q   <= 1'b1;
              done_q <= 1'b1;
            end
            OP_MUL, OP_MULU: st_q <= ST_MUL;
            OP_DIV, OP_DIVU: begin
              if (div_zero) begin
                res_q  <= '0;
                cy_q   <= 1'b1;
                ov_q   <= 1'b0;
                rng_q  <= ove_i;
                wr_q   <= 1'b0;
                done_q <= 1'b1;
              end else begin
                st_q <= ST_DIV;
              end
            end
            default: begin
              res_q  <= lg_res;
              cy_q   <= cy_i;
              ov_q   <= ov_i;
              rng_q  <= 1'b0;
              wr_q   <= 1'b1;
              done_q <= 1'b1;
            end
          endcase
        end
        ST_MUL: if (mul_done) begin
          res_q  <= mul_lo;
          cy_q   <= (mul_hi != '0);
          ov_q   <= (op_q == OP_MUL) && mul_sov;
          rng_q  <= (op_q == OP_MUL) && mul_sov && ove_q;
          wr_q   <= 1'b1;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        ST_DIV: if (div_done) begin
          res_q  <= neg_q ? -div_quo : div_quo;
          cy_q   <= 1'b0;
          ov_q   <= 1'b0;
          rng_q  <= 1'b0;
          wr_q   <= 1'b1;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign result_o    = res_q;
  assign wr_en_o     = wr_q;
  assign cy_o        = cy_q;
  assign ov_o        = ov_q;
  assign range_exc_o = rng_q;

  assert_ovf_range_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (op_q inside {OP_ADD, OP_ADDC, OP_SUB, OP_MUL}) |-> range_exc_o == (ove_q && ov_o));
  assert_div_range_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (op_q inside {OP_DIV, OP_DIVU}) |-> range_exc_o == (ove_q && cy_o));
  assert_no_ovf_div_mulu_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (op_q inside {OP_DIV, OP_DIVU, OP_MULU}) |-> !ov_o);
  assert_divzero_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (op_q inside {OP_DIV, OP_DIVU}) |-> wr_en_o == !cy_o);
  assert_logic_flags_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (op_q >= OP_AND) |-> (cy_o == cyin_q) && (ov_o == ovin_q) && !range_exc_o);
  assert_done_outside_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_busy_holds_op_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(op_q));
endmodule

// File: tb/int_alu_tb.sv
`timescale 1ns/1ps
module int_alu_tb;
  localparam int W = 32;
  localparam int MLAT = W + 1;
  localparam logic [3:0] C_ADD = 4'd0, C_ADDC = 4'd1, C_SUB = 4'd2, C_MUL = 4'd3,
                         C_MULU = 4'd4, C_DIV = 4'd5, C_DIVU = 4'd6, C_AND = 4'd7,
                         C_OR = 4'd8, C_XOR = 4'd9, C_SLL = 4'd10, C_SRL = 4'd11,
                         C_SRA = 4'd12, C_ROR = 4'd13, C_RSV = 4'd15;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [3:0]    op_i = '0;
  logic [W-1:0]  a_i = '0, b_i = '0;
  logic          cy_i = 1'b0, ov_i = 1'b0, ove_i = 1'b0;
  logic          busy_o, done_o, wr_en_o, cy_o, ov_o, range_exc_o;
  logic [W-1:0]  result_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk_i = ~clk_i;

  int_alu #(.WIDTH(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .cy_i(cy_i), .ov_i(ov_i), .ove_i(ove_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .wr_en_o(wr_en_o),
    .cy_o(cy_o), .ov_o(ov_o), .range_exc_o(range_exc_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic cyi, input logic ovi, input logic ovei, output int lat);
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b; cy_i = cyi; ov_i = ovi; ove_i = ovei;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 100) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  task automatic expect_op(input string tag, input logic [3:0] op, input logic [31:0] a,
                           input logic [31:0] b, input logic cyi, input logic ovi, input logic ovei,
                           input logic [31:0] er, input logic ecy, input logic eov,
                           input logic eexc, input logic ewr, input int elat);
    int lat;
    run_op(op, a, b, cyi, ovi, ovei, lat);
    chk(tag, "latency", lat, elat);
    chk(tag, "result", result_o, er);
    chk(tag, "carry", {31'd0, cy_o}, {31'd0, ecy});
    chk(tag, "overflow", {31'd0, ov_o}, {31'd0, eov});
    chk(tag, "range", {31'd0, range_exc_o}, {31'd0, eexc});
    chk(tag, "wr_en", {31'd0, wr_en_o}, {31'd0, ewr});
  endtask

  task automatic t_reset();
    chk("R13", "done", {31'd0, done_o}, 32'd0);
    chk("R13", "busy", {31'd0, busy_o}, 32'd0);
    chk("R13", "result", result_o, 32'd0);
    chk("R13", "flags", {28'd0, cy_o, ov_o, range_exc_o, wr_en_o}, 32'd0);
  endtask

  task automatic t_add();
    expect_op("R2", C_ADD, 32'h7FFFFFFF, 32'h1, 0, 0, 1, 32'h80000000, 0, 1, 1, 1, 0);
    expect_op("R2", C_ADD, 32'hFFFFFFFF, 32'h1, 0, 0, 1, 32'h0, 1, 0, 0, 1, 0);
    expect_op("R2", C_ADD, 32'h80000000, 32'h80000000, 0, 0, 0, 32'h0, 1, 1, 0, 1, 0);
    expect_op("R2", C_ADD, 32'h5, 32'h3, 1, 1, 1, 32'h8, 0, 0, 0, 1, 0);
  endtask

  task automatic t_addc();
    expect_op("R3", C_ADDC, 32'h0, 32'hFFFFFFFF, 1, 0, 1, 32'h0, 1, 0, 0, 1, 0);
    expect_op("R3", C_ADDC, 32'h1, 32'h2, 1, 0, 0, 32'h4, 0, 0, 0, 1, 0);
    expect_op("R3", C_ADDC, 32'h7FFFFFFF, 32'h0, 1, 0, 1, 32'h80000000, 0, 1, 1, 1, 0);
    expect_op("R3", C_ADDC, 32'hFFFFFFFF, 32'hFFFFFFFF, 1, 0, 0, 32'hFFFFFFFF, 1, 0, 0, 1, 0);
    expect_op("R3", C_ADDC, 32'h1, 32'h2, 0, 0, 0, 32'h3, 0, 0, 0, 1, 0);
  endtask

  task automatic t_sub();
    expect_op("R4", C_SUB, 32'h5, 32'h3, 0, 0, 1, 32'h2, 0, 0, 0, 1, 0);
    expect_op("R4", C_SUB, 32'h3, 32'h5, 0, 0, 1, 32'hFFFFFFFE, 1, 0, 0, 1, 0);
    expect_op("R4", C_SUB, 32'h80000000, 32'h1, 0, 0, 1, 32'h7FFFFFFF, 0, 1, 1, 1, 0);
    expect_op("R4", C_SUB, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 0, 0, 32'h80000000, 1, 1, 0, 1, 0);
  endtask

  task automatic t_mul();
    expect_op("R5", C_MUL, 32'h3, 32'hFFFFFFFE, 0, 1, 1, 32'hFFFFFFFA, 1, 0, 0, 1, MLAT);
    expect_op("R5", C_MUL, 32'h10000, 32'h10000, 0, 0, 1, 32'h0, 1, 1, 1, 1, MLAT);
    expect_op("R5", C_MUL, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0, 1, 32'h1, 1, 0, 0, 1, MLAT);
    expect_op("R5", C_MUL, 32'h80000000, 32'hFFFFFFFF, 0, 0, 0, 32'h80000000, 1, 1, 0, 1, MLAT);
    expect_op("R5", C_MUL, 32'h1234, 32'h10, 1, 1, 1, 32'h12340, 0, 0, 0, 1, MLAT);
  endtask

  task automatic t_mulu();
    expect_op("R6", C_MULU, 32'h10000, 32'h10000, 0, 1, 1, 32'h0, 1, 0, 0, 1, MLAT);
    expect_op("R6", C_MULU, 32'hFFFF, 32'hFFFF, 1, 1, 1, 32'hFFFE0001, 0, 0, 0, 1, MLAT);
  endtask

  task automatic t_div();
    expect_op("R7", C_DIV, 32'h7, 32'h2, 1, 1, 1, 32'h3, 0, 0, 0, 1, MLAT);
    expect_op("R7", C_DIV, 32'hFFFFFFF9, 32'h2, 1, 1, 1, 32'hFFFFFFFD, 0, 0, 0, 1, MLAT);
    expect_op("R7", C_DIV, 32'h7, 32'hFFFFFFFE, 0, 0, 0, 32'hFFFFFFFD, 0, 0, 0, 1, MLAT);
    expect_op("R7", C_DIV, 32'hFFFFFFF8, 32'hFFFFFFFE, 0, 0, 0, 32'h4, 0, 0, 0, 1, MLAT);
    expect_op("R7", C_DIVU, 32'hFFFFFFF9, 32'h2, 1, 1, 1, 32'h7FFFFFFC, 0, 0, 0, 1, MLAT);
  endtask

  task automatic t_divzero();
    expect_op("R8", C_DIV, 32'h5, 32'h0, 0, 1, 1, 32'h0, 1, 0, 1, 0, 0);
    expect_op("R8", C_DIVU, 32'h5, 32'h0, 0, 0, 0, 32'h0, 1, 0, 0, 0, 0);
  endtask

  task automatic t_logic();
    expect_op("R10", C_AND, 32'hF0F0, 32'hFF00, 1, 1, 1, 32'hF000, 1, 1, 0, 1, 0);
    expect_op("R10", C_OR,  32'hF0F0, 32'hFF00, 0, 1, 1, 32'hFFF0, 0, 1, 0, 1, 0);
    expect_op("R10", C_XOR, 32'hF0F0, 32'hFF00, 1, 0, 0, 32'h0FF0, 1, 0, 0, 1, 0);
    expect_op("R10", C_RSV, 32'h1234, 32'h5678, 1, 1, 1, 32'h0, 1, 1, 0, 1, 0);
  endtask

  task automatic t_shift();
    expect_op("R11", C_SLL, 32'h1, 32'd33, 0, 0, 1, 32'h2, 0, 0, 0, 1, 0);
    expect_op("R11", C_SRL, 32'h80000000, 32'd31, 1, 0, 0, 32'h1, 1, 0, 0, 1, 0);
    expect_op("R11", C_SRA, 32'h80000000, 32'd4, 0, 1, 0, 32'hF8000000, 0, 1, 0, 1, 0);
    expect_op("R11", C_ROR, 32'h12345678, 32'd8, 0, 0, 0, 32'h78123456, 0, 0, 0, 1, 0);
    expect_op("R11", C_ROR, 32'h12345678, 32'd32, 0, 0, 0, 32'h12345678, 0, 0, 0, 1, 0);
    expect_op("R11", C_ROR, 32'h1, 32'd1, 0, 0, 0, 32'h80000000, 0, 0, 0, 1, 0);
  endtask

  task automatic t_hold();
    expect_op("R1", C_ADD, 32'h100, 32'h23, 0, 0, 0, 32'h123, 0, 0, 0, 1, 0);
    repeat (3) @(negedge clk_i);
    chk("R1", "done after pulse", {31'd0, done_o}, 32'd0);
    chk("R1", "result held", result_o, 32'h123);
  endtask

  task automatic t_busy_ignore();
    int first_k = -1;
    int n_done = 0;
    logic busy_seen = 1'b0;
    @(negedge clk_i);
    start_i = 1'b1; op_i = C_MUL; a_i = 32'h10000; b_i = 32'h3; cy_i = 0; ov_i = 0; ove_i = 0;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < MLAT + 8; k++) begin
      if (k == 1) busy_seen = busy_o;
      if (k == 3) begin start_i = 1'b1; op_i = C_ADD; a_i = 32'h1; b_i = 32'h1; end
      if (k == 4) start_i = 1'b0;
      if (done_o) begin
        n_done++;
        if (first_k < 0) begin
          first_k = k;
          chk("R12", "result of busy op", result_o, 32'h30000);
        end
      end
      @(negedge clk_i);
    end
    chk("R12", "busy while running", {31'd0, busy_seen}, 32'd1);
    chk("R12", "completion cycle", first_k, MLAT);
    chk("R12", "completion count", n_done, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_add();
    t_addc();
    t_sub();
    t_mul();
    t_mulu();
    t_div();
    t_divzero();
    t_logic();
    t_shift();
    t_hold();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule